// File: doc/BRIEF.md
# Debug Control Register with Event Qualifier

This block holds the processor's debug control word. Software writes and reads it through a special-register port with a select, a write enable, a 32-bit write word and a 32-bit read word. The read word is valid in the same cycle the select is high. The stored word enables the two debug modes and five kinds of debug event. A 2-bit field in the word asks for a reset of a chosen scope whenever software writes a nonzero value into it.

Each cycle the pipeline reports which occurrences happened: instruction completion, taken branch, interrupt (with a flag for critical interrupts), trap, and a match on instruction-address comparator 1. The block turns these into qualified debug events. An occurrence becomes an event only if its enable bit is set and at least one debug mode is on. Further rules depend on the machine-state debug-enable input and the debug-wait-mode input. Every qualified event and every reset request leaves the block as a registered one-cycle pulse.

Top module: `dbg_ctl_qual`

## Requirements
- R1: During and right after reset, the stored word is all zeros, every event output and every reset request is low, and a read returns 0.
- R2: Bits are numbered big-endian: control bit n sits at word index 31-n. Implemented bits are bit 0 (external mode), bit 1 (internal mode), bit 4 (completion enable), bit 5 (branch enable), bit 6 (interrupt enable), bit 7 (trap enable) and bit 8 (compare-1 enable). With the select high, the read word shows the stored value in the same cycle. Bits 9 to 31 always read 0. With the select low, the read word is 0.
- R3: The stored word changes only in a cycle where both select and write enable are high. It then takes the implemented bits of the write word from the next cycle on.
- R4: A write whose bits 2:3 (word indices 29:28) hold 01, 10 or 11 gives exactly one one-cycle pulse, in the cycle after the write, on the core, chip or system reset request respectively. A value of 00 or no write gives no pulse, and at most one request is high at a time.
- R5: The reset field (bits 2:3) always reads back as 00.
- R6: An event output pulses in the cycle after its occurrence input is high. It pulses only if its enable bit is set and internal or external mode is on, both judged by the stored word in the occurrence cycle.
- R7: Completion and taken-branch events are dropped when machine-state debug enable is 0, unless external mode or debug-wait mode is active.
- R8: A critical interrupt gives an interrupt event only when external mode or debug-wait mode is active.
- R9: Non-critical interrupts, traps and compare-1 matches are qualified by enable and mode alone, whatever the machine-state debug enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spr_sel | input | 1 | Register port select |
| spr_we | input | 1 | Write enable, effective with select |
| spr_wdata | input | 32 | Write word |
| spr_rdata | output | 32 | Read word, same cycle |
| occ_icmp | input | 1 | Instruction completed |
| occ_brt | input | 1 | Branch taken |
| occ_irpt | input | 1 | Interrupt taken |
| occ_irpt_crit | input | 1 | The interrupt is critical |
| occ_trap | input | 1 | Trap occurred |
| occ_iac1 | input | 1 | Address comparator 1 matched |
| msr_de | input | 1 | Machine-state debug enable |
| dbg_wait | input | 1 | Debug-wait mode active |
| evt_icmp | output | 1 | Qualified completion event |
| evt_brt | output | 1 | Qualified taken-branch event |
| evt_irpt | output | 1 | Qualified interrupt event |
| evt_trap | output | 1 | Qualified trap event |
| evt_iac1 | output | 1 | Qualified compare-1 event |
| rst_core | output | 1 | Core reset request pulse |
| rst_chip | output | 1 | Chip reset request pulse |
| rst_sys | output | 1 | System reset request pulse |

## Verification
The assertions assume the critical flag has meaning only alongside an interrupt occurrence. They also assume a write and a read may share a cycle, in which case the read shows the old word. No assumption is made about how often occurrences arrive. The stimulus drives the critical flag freely and mixes reads and writes in the same cycle, so both situations come up. Because writes are only occasional, a mode setting stays in place long enough for the gating rules to see many occurrence patterns. Writes carry random reset fields, so every reset scope and the no-action value all appear.

// File: rtl/dbg_ctl_pkg.sv
package dbg_ctl_pkg;

    localparam int WORD_W   = 32;
    localparam int NUM_EVT  = 5;
    localparam int NUM_RSTK = 3;

    // big-endian control bit n lives at word index WORD_W-1-n
    localparam int B_EDM    = WORD_W - 1 - 0;
    localparam int B_IDM    = WORD_W - 1 - 1;
    localparam int B_RST_HI = WORD_W - 1 - 2;
    localparam int B_RST_LO = WORD_W - 1 - 3;
    localparam int B_ICMP   = WORD_W - 1 - 4;
    localparam int B_BRT    = WORD_W - 1 - 5;
    localparam int B_IRPT   = WORD_W - 1 - 6;
    localparam int B_TRAP   = WORD_W - 1 - 7;
    localparam int B_IAC1   = WORD_W - 1 - 8;

    // event vector positions
    localparam int EV_ICMP = 0;
    localparam int EV_BRT  = 1;
    localparam int EV_IRPT = 2;
    localparam int EV_TRAP = 3;
    localparam int EV_IAC1 = 4;

    typedef enum logic [1:0] {
        RSTK_NONE = 2'b00,
        RSTK_CORE = 2'b01,
        RSTK_CHIP = 2'b10,
        RSTK_SYS  = 2'b11
    } rst_kind_e;

    typedef struct packed {
        logic                edm;
        logic                idm;
        logic [NUM_EVT-1:0]  en;
    } ctl_t;

    function automatic ctl_t word_to_ctl(input logic [WORD_W-1:0] w);
        ctl_t c;
        c.edm          = w[B_EDM];
        c.idm          = w[B_IDM];
        c.en[EV_ICMP]  = w[B_ICMP];
        c.en[EV_BRT]   = w[B_BRT];
        c.en[EV_IRPT]  = w[B_IRPT];
        c.en[EV_TRAP]  = w[B_TRAP];
        c.en[EV_IAC1]  = w[B_IAC1];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctl_to_word(input ctl_t c);
        logic [WORD_W-1:0] w;
        w          = '0;
        w[B_EDM]   = c.edm;
        w[B_IDM]   = c.idm;
        w[B_ICMP]  = c.en[EV_ICMP];
        w[B_BRT]   = c.en[EV_BRT];
        w[B_IRPT]  = c.en[EV_IRPT];
        w[B_TRAP]  = c.en[EV_TRAP];
        w[B_IAC1]  = c.en[EV_IAC1];
        return w;
    endfunction

    function automatic rst_kind_e word_to_rstk(input logic [WORD_W-1:0] w);
        return rst_kind_e'(w[B_RST_HI:B_RST_LO]);
    endfunction

endpackage

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg
    import dbg_ctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 we,
    input  logic [WORD_W-1:0]    wdata,
    output logic [WORD_W-1:0]    rdata,
    output ctl_t                 ctl,
    output logic [NUM_RSTK-1:0]  rst_req
);

    typedef struct packed {
        ctl_t                ctl;
        logic [NUM_RSTK-1:0] req;
    } reg_state_t;

    reg_state_t s_d, s_q;
    rst_kind_e  wr_kind;

    assign wr_kind = word_to_rstk(wdata);

    always_comb begin
        s_d     = s_q;
        s_d.req = '0;
        if (sel && we) begin
            s_d.ctl = word_to_ctl(wdata);
            // request index k-1 answers to field code k
            for (int k = 1; k <= NUM_RSTK; k++) begin
                s_d.req[k-1] = (wr_kind == rst_kind_e'(k));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // the reset field is never stored, so it reads back 00
    always_comb begin
        rdata = '0;
        if (sel) begin
            rdata = ctl_to_word(s_q.ctl);
        end
    end

    assign ctl     = s_q.ctl;
    assign rst_req = s_q.req;

endmodule

// File: rtl/dbg_evt_qual.sv
module dbg_evt_qual
    import dbg_ctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  ctl_t                ctl,
    input  logic [NUM_EVT-1:0]  occ,
    input  logic                irpt_crit,
    input  logic                msr_de,
    input  logic                dbg_wait,
    output logic [NUM_EVT-1:0]  evt
);

    typedef struct packed {
        logic [NUM_EVT-1:0] evt;
    } qual_state_t;

    qual_state_t        s_d, s_q;
    logic               mode_on;
    logic               relax;
    logic [NUM_EVT-1:0] pass;

    assign mode_on = ctl.idm | ctl.edm;
    assign relax   = ctl.edm | dbg_wait;

    always_comb begin
        pass          = '1;
        pass[EV_ICMP] = msr_de | relax;
        pass[EV_BRT]  = msr_de | relax;
        pass[EV_IRPT] = ~irpt_crit | relax;
    end

    always_comb begin
        s_d     = s_q;
        s_d.evt = occ & ctl.en & pass & {NUM_EVT{mode_on}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign evt = s_q.evt;

endmodule

// File: rtl/dbg_ctl_qual.sv
module dbg_ctl_qual
    import dbg_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spr_sel,
    input  logic              spr_we,
    input  logic [WORD_W-1:0] spr_wdata,
    output logic [WORD_W-1:0] spr_rdata,
    input  logic              occ_icmp,
    input  logic              occ_brt,
    input  logic              occ_irpt,
    input  logic              occ_irpt_crit,
    input  logic              occ_trap,
    input  logic              occ_iac1,
    input  logic              msr_de,
    input  logic              dbg_wait,
    output logic              evt_icmp,
    output logic              evt_brt,
    output logic              evt_irpt,
    output logic              evt_trap,
    output logic              evt_iac1,
    output logic              rst_core,
    output logic              rst_chip,
    output logic              rst_sys
);

    ctl_t                ctl_w;
    logic [NUM_EVT-1:0]  occ_w;
    logic [NUM_EVT-1:0]  evt_w;
    logic [NUM_RSTK-1:0] req_w;
    logic                mode_edm;
    logic                mode_idm;

    always_comb begin
        occ_w          = '0;
        occ_w[EV_ICMP] = occ_icmp;
        occ_w[EV_BRT]  = occ_brt;
        occ_w[EV_IRPT] = occ_irpt;
        occ_w[EV_TRAP] = occ_trap;
        occ_w[EV_IAC1] = occ_iac1;
    end

    dbg_ctl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (spr_sel),
        .we      (spr_we),
        .wdata   (spr_wdata),
        .rdata   (spr_rdata),
        .ctl     (ctl_w),
        .rst_req (req_w)
    );

    dbg_evt_qual u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl_w),
        .occ       (occ_w),
        .irpt_crit (occ_irpt_crit),
        .msr_de    (msr_de),
        .dbg_wait  (dbg_wait),
        .evt       (evt_w)
    );

    assign mode_edm = ctl_w.edm;
    assign mode_idm = ctl_w.idm;

    assign evt_icmp = evt_w[EV_ICMP];
    assign evt_brt  = evt_w[EV_BRT];
    assign evt_irpt = evt_w[EV_IRPT];
    assign evt_trap = evt_w[EV_TRAP];
    assign evt_iac1 = evt_w[EV_IAC1];

    assign rst_core = req_w[0];
    assign rst_chip = req_w[1];
    assign rst_sys  = req_w[2];

endmodule

// File: rtl/dbg_ctl_qual_chk.sv
module dbg_ctl_qual_chk
    import dbg_ctl_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               spr_sel,
    input logic               spr_we,
    input logic [1:0]         wr_fld,
    input logic [WORD_W-1:0]  spr_rdata,
    input logic [NUM_EVT-1:0] occ,
    input logic               occ_irpt_crit,
    input logic               msr_de,
    input logic               dbg_wait,
    input logic               mode_edm,
    input logic               mode_idm,
    input logic [NUM_EVT-1:0] evt,
    input logic               rst_core,
    input logic               rst_chip,
    input logic               rst_sys
);

    localparam logic [WORD_W-1:0] IMPL_MASK =
        (WORD_W'(1) << B_EDM)  | (WORD_W'(1) << B_IDM)  |
        (WORD_W'(1) << B_ICMP) | (WORD_W'(1) << B_BRT)  |
        (WORD_W'(1) << B_IRPT) | (WORD_W'(1) << B_TRAP) |
        (WORD_W'(1) << B_IAC1);

    assert_rst_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_core, rst_chip, rst_sys}));

    assert_rst_core_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_sel && spr_we && wr_fld == 2'b01) |=> rst_core);

    assert_rst_sys_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_sel && spr_we && wr_fld == 2'b11) |=> rst_sys);

    assert_rst_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(spr_sel && spr_we) |=> !(rst_core || rst_chip || rst_sys));

    assert_unimpl_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_rdata & ~IMPL_MASK) == '0);

    assert_unsel_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !spr_sel |-> spr_rdata == '0);

    assert_rstfld_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spr_rdata[B_RST_HI:B_RST_LO] == 2'b00);

    assert_evt_needs_occ_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (evt & ~$past(occ)) == '0);

    assert_evt_needs_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_edm || mode_idm) |=> evt == '0);

    assert_msr_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!msr_de && !mode_edm && !dbg_wait) |=> !evt[EV_ICMP] && !evt[EV_BRT]);

    assert_crit_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_irpt_crit && !mode_edm && !dbg_wait) |=> !evt[EV_IRPT]);

endmodule

bind dbg_ctl_qual dbg_ctl_qual_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .spr_sel       (spr_sel),
    .spr_we        (spr_we),
    .wr_fld        (spr_wdata[29:28]),
    .spr_rdata     (spr_rdata),
    .occ           (occ_w),
    .occ_irpt_crit (occ_irpt_crit),
    .msr_de        (msr_de),
    .dbg_wait      (dbg_wait),
    .mode_edm      (mode_edm),
    .mode_idm      (mode_idm),
    .evt           (evt_w),
    .rst_core      (rst_core),
    .rst_chip      (rst_chip),
    .rst_sys       (rst_sys)
);

// File: tb/sim_dbg_ctl_qual.sv
`timescale 1ns/1ps
module sim_dbg_ctl_qual;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        spr_sel, spr_we;
    logic [31:0] spr_wdata, spr_rdata;
    logic        occ_icmp, occ_brt, occ_irpt, occ_irpt_crit, occ_trap, occ_iac1;
    logic        msr_de, dbg_wait;
    logic        evt_icmp, evt_brt, evt_irpt, evt_trap, evt_iac1;
    logic        rst_core, rst_chip, rst_sys;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_ctl;
    logic [4:0]  p_evt;
    logic [2:0]  p_rst;

    localparam logic [31:0] IMPL = 32'hCF80_0000;

    always #2.5 clk = ~clk;

    dbg_ctl_qual u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // events: bit0 completion, 1 branch, 2 interrupt, 3 trap, 4 compare-1
    function automatic logic [4:0] qual(input logic [31:0] c, input logic [4:0] occ,
                                        input logic crit, input logic msr, input logic wt);
        logic       mode, rel;
        logic [4:0] en, pass;
        mode = c[31] | c[30];
        rel  = c[31] | wt;
        en   = {c[23], c[24], c[25], c[26], c[27]};
        pass = {1'b1, 1'b1, (~crit | rel), (msr | rel), (msr | rel)};
        return occ & en & pass & {5{mode}};
    endfunction

    function automatic logic [2:0] rdec(input logic [1:0] f);
        case (f)
            2'b01:   return 3'b001;
            2'b10:   return 3'b010;
            2'b11:   return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    task automatic step(input logic sel, input logic we, input logic [31:0] wd,
                        input logic [4:0] occ, input logic crit,
                        input logic msr, input logic wt);
        @(negedge clk);
        chk("R6 R7 completion", {31'd0, evt_icmp}, {31'd0, p_evt[0]});
        chk("R6 R7 branch",     {31'd0, evt_brt},  {31'd0, p_evt[1]});
        chk("R6 R8 R9 irpt",    {31'd0, evt_irpt}, {31'd0, p_evt[2]});
        chk("R6 R9 trap",       {31'd0, evt_trap}, {31'd0, p_evt[3]});
        chk("R6 R9 iac1",       {31'd0, evt_iac1}, {31'd0, p_evt[4]});
        chk("R4 reset req",     {29'd0, rst_sys, rst_chip, rst_core}, {29'd0, p_rst});
        spr_sel = sel; spr_we = we; spr_wdata = wd;
        {occ_iac1, occ_trap, occ_irpt, occ_brt, occ_icmp} = occ;
        occ_irpt_crit = crit; msr_de = msr; dbg_wait = wt;
        #1;
        chk("R2 R3 R5 readback", spr_rdata, sel ? m_ctl : 32'd0);
        p_evt = qual(m_ctl, occ, crit, msr, wt);
        p_rst = (sel && we) ? rdec(wd[29:28]) : 3'b000;
        if (sel && we) m_ctl = wd & IMPL;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; spr_sel = 1'b1; spr_we = 1'b0; spr_wdata = '0;
        {occ_iac1, occ_trap, occ_irpt, occ_brt, occ_icmp} = '1;
        occ_irpt_crit = 1'b0; msr_de = 1'b1; dbg_wait = 1'b1;
        m_ctl = '0; p_evt = '0; p_rst = '0;
        repeat (3) @(negedge clk);
        chk("R1 readback", spr_rdata, 32'd0);
        chk("R1 events", {27'd0, evt_iac1, evt_trap, evt_irpt, evt_brt, evt_icmp}, 32'd0);
        chk("R1 resets", {29'd0, rst_sys, rst_chip, rst_core}, 32'd0);
        rst_n = 1'b1;

        // R3 R4 full write then readback, system reset
        step(1, 1, 32'hFFFF_FFFF, 5'h00, 0, 1, 0);
        step(1, 0, 32'h0,         5'h1F, 0, 1, 0);
        // R4 core and chip scopes
        step(1, 1, 32'h1000_0000, 5'h00, 0, 1, 0);
        step(1, 1, 32'h2000_0000, 5'h00, 0, 1, 0);
        // R3 write without select is ignored
        step(0, 1, 32'hFFFF_FFFF, 5'h00, 0, 1, 0);
        step(1, 0, 32'h0,         5'h00, 0, 1, 0);
        // internal mode only: R7 and R8 gating
        step(1, 1, 32'h4E00_0000, 5'h00, 0, 1, 0);
        step(0, 0, 32'h0, 5'h07, 1, 0, 0);
        step(0, 0, 32'h0, 5'h07, 1, 0, 1);
        step(0, 0, 32'h0, 5'h07, 1, 1, 0);
        step(0, 0, 32'h0, 5'h04, 0, 0, 0);
        // external mode only: R8 critical interrupt fires
        step(1, 1, 32'h8E00_0000, 5'h00, 0, 0, 0);
        step(0, 0, 32'h0, 5'h07, 1, 0, 0);
        // R6 no mode: enables alone give nothing
        step(1, 1, 32'h0F80_0000, 5'h00, 0, 1, 1);
        step(0, 0, 32'h0, 5'h1F, 0, 1, 1);
        // R9 trap and compare-1 with machine-state bit low
        step(1, 1, 32'h4180_0000, 5'h00, 0, 0, 0);
        step(0, 0, 32'h0, 5'h18, 0, 0, 0);

        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 3) != 0, ($urandom % 5) == 0, $urandom,
                 5'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        step(0, 0, 32'h0, 5'h00, 0, 0, 0);
        step(0, 0, 32'h0, 5'h00, 0, 0, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule